// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer. The timer steps once every four prescaled clock units. Its count, extended below by two sub-count bits, forms a 10-bit time base. Each period runs from time base zero until the timer reaches the programmed period value. On the increment after that, the timer returns to zero and the output goes high. The output goes low again when the time base reaches the active 10-bit duty value.

The duty value is supplied as an 8-bit upper part and a 2-bit lower part. These inputs may change at any moment. The block copies them into its active compare register only at the period boundary, so a change made partway through a period never cuts a pulse short or stretches it. A one-clock period-match pulse marks each boundary so that neighbouring logic can follow the PWM frame.

Top module: `pwm_gen`

## Requirements
- R1: While rstN is low, pwmOut and periodMatch are 0. After reset the timer, the sub-count and the active duty are all zero.
- R2: The time base advances one step every P clocks. P is 1, 4 or 16 for preSel 0, 1, or 2/3 respectively. The timer therefore increments once every 4·P clocks, and the two sub-count bits are the clock phase (P=1) or the upper two prescaler bits (P=4, 16).
- R3: The timer counts from 0 up to periodVal, so one period lasts (periodVal+1)·4·P clocks. periodMatch is 1 for exactly one clock, the last clock of each period, and only while enable is 1.
- R4: At the edge that ends a period, the block copies {dutyHi,dutyLo} into the active duty. If that value is nonzero, pwmOut goes to 1.
- R5: Changing dutyHi or dutyLo partway through a period has no effect on that period's pulse. The new value applies from the next period on.
- R6: pwmOut goes to 0 when the 10-bit time base equals the active duty, so the pulse lasts duty·P clocks.
- R7: An active duty of 0 keeps pwmOut at 0 for the whole period.
- R8: An active duty of (periodVal+1)·4 or more keeps pwmOut at 1 for the whole period.
- R9: While enable is 0, pwmOut is 0 from the next clock on and the timer and sub-count are held at zero. After enable rises, pwmOut stays 0 until the first period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the timer; when 0, holds the time base at zero and drives the output low |
| preSel | input | 2 | Prescale select: 0 gives 1, 1 gives 4, 2 or 3 gives 16 |
| periodVal | input | 8 | Last timer count of each period |
| dutyHi | input | 8 | Upper eight bits of the next duty value |
| dutyLo | input | 2 | Lower two bits of the next duty value |
| pwmOut | output | 1 | PWM output |
| periodMatch | output | 1 | High during the final clock of each period |

## Verification
The bench attacks the double buffer by rewriting the duty value three clocks into a period. A design that latched the value straight away would give a shortened pulse in that same period. The bench also drives a duty of zero and a duty that exactly equals the period length. A design that set the pin without checking for zero would emit a one-clock spike, and one that used the wrong compare bound would drop low for one step. Each prescale setting, including the alias code 3, is run against measured pulse widths, which exposes a wrong choice of sub-count bits as a width off by a factor of four. Disabling the block partway through a period and then re-enabling it checks that the output drops at once and stays low through the first period after enable.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int SUB_W = 2;

  localparam logic [1:0] PRE_SEL_1 = 2'd0;
  localparam logic [1:0] PRE_SEL_4 = 2'd1;

  typedef struct packed {
    logic             hold;     // enable low: clear time base, drop pin
    logic             bump;     // timer steps by one
    logic             roll;     // period boundary: clear timer, set pin, latch duty
    logic [SUB_W-1:0] subNext;  // sub-count bits after this edge
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int PRE_LOG_MID = 2,
  parameter int PRE_LOG_MAX = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  preSel,
  input  logic        atPeriod,
  output pwmStrobes_t strobes
);
  localparam int TICK_W = SUB_W + PRE_LOG_MAX;
  localparam logic [TICK_W-1:0] LAST_1   = TICK_W'((1 << SUB_W) - 1);
  localparam logic [TICK_W-1:0] LAST_MID = TICK_W'((1 << (SUB_W + PRE_LOG_MID)) - 1);
  localparam logic [TICK_W-1:0] LAST_MAX = '1;

  logic [TICK_W-1:0] tick, tickNext, tickLast;
  logic              wrap;

  always_comb begin
    case (preSel)
      PRE_SEL_1: tickLast = LAST_1;
      PRE_SEL_4: tickLast = LAST_MID;
      default:   tickLast = LAST_MAX;
    endcase
  end

  assign wrap = (tick >= tickLast);

  always_comb begin
    if (!enable)   tickNext = '0;
    else if (wrap) tickNext = '0;
    else           tickNext = tick + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tick <= '0;
    else       tick <= tickNext;
  end

  always_comb begin
    strobes.hold = !enable;
    strobes.bump = enable && wrap && !atPeriod;
    strobes.roll = enable && wrap && atPeriod;
    case (preSel)
      PRE_SEL_1: strobes.subNext = tickNext[SUB_W-1:0];
      PRE_SEL_4: strobes.subNext = tickNext[PRE_LOG_MID +: SUB_W];
      default:   strobes.subNext = tickNext[PRE_LOG_MAX +: SUB_W];
    endcase
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwmStrobes_t        strobes,
  input  logic [TIMER_W-1:0] periodVal,
  input  logic [TIMER_W-1:0] dutyHi,
  input  logic [SUB_W-1:0]   dutyLo,
  output logic               atPeriod,
  output logic               pwmOut
);
  localparam int DUTY_W = TIMER_W + SUB_W;

  logic [TIMER_W-1:0] timer, timerNext;
  logic [DUTY_W-1:0]  activeDuty, activeNext, dutyWord, baseNext;
  logic               pinQ, pinNext;

  assign atPeriod = (timer == periodVal);
  assign dutyWord = {dutyHi, dutyLo};

  always_comb begin
    if (strobes.hold || strobes.roll) timerNext = '0;
    else if (strobes.bump)            timerNext = timer + TIMER_W'(1);
    else                              timerNext = timer;
  end

  assign activeNext = strobes.roll ? dutyWord : activeDuty;
  assign baseNext   = {timerNext, strobes.subNext};

  always_comb begin
    if (strobes.hold)                 pinNext = 1'b0;
    else if (strobes.roll)            pinNext = (dutyWord != '0);
    else if (baseNext == activeDuty)  pinNext = 1'b0;
    else                              pinNext = pinQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer      <= '0;
      activeDuty <= '0;
      pinQ       <= 1'b0;
    end else begin
      timer      <= timerNext;
      activeDuty <= activeNext;
      pinQ       <= pinNext;
    end
  end

  assign pwmOut = pinQ;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TIMER_W     = 8,
  parameter int PRE_LOG_MID = 2,
  parameter int PRE_LOG_MAX = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         preSel,
  input  logic [TIMER_W-1:0] periodVal,
  input  logic [TIMER_W-1:0] dutyHi,
  input  logic [SUB_W-1:0]   dutyLo,
  output logic               pwmOut,
  output logic               periodMatch
);
  pwmStrobes_t strobes;
  logic        atPeriod;

  pwm_ctrl #(.PRE_LOG_MID(PRE_LOG_MID), .PRE_LOG_MAX(PRE_LOG_MAX)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .preSel   (preSel),
    .atPeriod (atPeriod),
    .strobes  (strobes)
  );

  pwm_datapath #(.TIMER_W(TIMER_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .periodVal (periodVal),
    .dutyHi    (dutyHi),
    .dutyLo    (dutyLo),
    .atPeriod  (atPeriod),
    .pwmOut    (pwmOut)
  );

  assign periodMatch = strobes.roll;
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker
  import pwm_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic [TIMER_W-1:0] periodVal,
  input logic [TIMER_W-1:0] dutyHi,
  input logic [SUB_W-1:0]   dutyLo,
  input logic               pwmOut,
  input logic               periodMatch
);
  localparam int DW = TIMER_W + SUB_W + 1;

  logic [DW-1:0] dutyExt, fullSpan;
  assign dutyExt  = {1'b0, dutyHi, dutyLo};
  assign fullSpan = (DW'(periodVal) + DW'(1)) << SUB_W;

  a_r9_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);

  a_r3_match_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    periodMatch |-> enable);

  a_r4_rise_after_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(periodMatch));

  a_r4_set_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (periodMatch && dutyExt != '0) |=> pwmOut);

  a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (periodMatch && dutyExt == '0) |=> !pwmOut);

  a_r8_full_duty: assert property (@(posedge clk) disable iff (!rstN)
    (periodMatch && dutyExt >= fullSpan) |=> pwmOut);
endmodule

bind pwm_gen pwm_gen_checker #(.TIMER_W(TIMER_W)) chkInst (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .periodVal   (periodVal),
  .dutyHi      (dutyHi),
  .dutyLo      (dutyLo),
  .pwmOut      (pwmOut),
  .periodMatch (periodMatch)
);

// File: tb/pwm_gen_test.sv
`timescale 1ns/1ps
module pwm_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] preSel = 2'd0;
  logic [7:0] periodVal = 8'd0;
  logic [7:0] dutyHi = 8'd0;
  logic [1:0] dutyLo = 2'd0;
  logic       pwmOut, periodMatch;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  pwm_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .preSel(preSel),
    .periodVal(periodVal), .dutyHi(dutyHi), .dutyLo(dutyLo),
    .pwmOut(pwmOut), .periodMatch(periodMatch)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mTick = 0, mTimer = 0, mActive = 0;
  bit mStarted = 0;

  function automatic int preOf(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mTimer = 0; mActive = 0; mStarted = 0;
    end else if (!enable) begin
      mTick = 0; mTimer = 0; mStarted = 0;
    end else begin
      mTick++;
      if (mTick == 4 * preOf(preSel)) begin
        mTick = 0;
        if (mTimer == int'(periodVal)) begin
          mTimer = 0; mActive = int'({dutyHi, dutyLo}); mStarted = 1;
        end else mTimer++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int p;
      bit expPin, expMatch;
      p = preOf(preSel);
      expPin = mStarted && ((mTimer * 4 + mTick / p) < mActive);
      expMatch = enable && (mTimer == int'(periodVal)) && (mTick == 4 * p - 1);
      check({curReq, " pin"}, int'(pwmOut), int'(expPin));
      check({curReq, " match"}, int'(periodMatch), int'(expMatch));
    end
  end

  task automatic setDuty(input int d);
    dutyHi = 8'(d >> 2);
    dutyLo = 2'(d);
  endtask

  // Waits for a boundary, then counts high cycles across the next period.
  task automatic measure(input string req, input int expHigh, input int newDuty);
    int n, highs, matchEarly, waited;
    bit matchEnd;
    n = (int'(periodVal) + 1) * 4 * preOf(preSel);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!periodMatch && waited < 20000);
    check({req, " boundary seen"}, int'(periodMatch), 1);
    highs = 0; matchEarly = 0; matchEnd = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (pwmOut) highs++;
      if (periodMatch) begin
        if (k == n) matchEnd = 1; else matchEarly++;
      end
      if (k == 3 && newDuty >= 0) begin
        #1 setDuty(newDuty);
      end
    end
    check({req, " high clocks"}, highs, expHigh);
    check({req, " R3 period length"}, int'(matchEnd), 1);
    check({req, " R3 no early match"}, matchEarly, 0);
  endtask

  task automatic restart(input logic [1:0] sel, input int per, input int d);
    @(posedge clk); #2;
    enable = 1'b0;
    @(posedge clk); #2;
    preSel = sel; periodVal = 8'(per); setDuty(d);
    enable = 1'b1;
  endtask

  initial begin
    int highs;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pin in reset", int'(pwmOut), 0);
    check("R1 match in reset", int'(periodMatch), 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pin after reset", int'(pwmOut), 0);

    // R9 + R6: first period low, then duty 7 at 1:1 prescale
    curReq = "R9";
    periodVal = 8'd4; setDuty(7); preSel = 2'd0;
    @(posedge clk); #2;
    enable = 1'b1;
    highs = 0;
    for (int k = 0; k < 19; k++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
    check("R9 low before first boundary", highs, 0);
    curReq = "R6";
    measure("R6 duty7 P1", 7, -1);

    // R5: mid-period rewrite takes effect one period later
    curReq = "R5";
    measure("R5 old duty kept", 7, 2);
    measure("R5 new duty applied", 2, -1);

    // R7: zero duty
    curReq = "R7";
    setDuty(0);
    measure("R7 zero duty", 0, -1);

    // R8: duty equal to and above the period span
    curReq = "R8";
    setDuty(20);
    measure("R8 duty equals span", 20, -1);
    setDuty(1023);
    measure("R8 duty max", 20, -1);

    // R2: prescale 4 and 16, including alias code 3
    curReq = "R2";
    restart(2'd1, 2, 5);
    measure("R2 pre4 duty5", 20, -1);
    restart(2'd2, 1, 3);
    measure("R2 pre16 duty3", 48, -1);
    restart(2'd3, 0, 2);
    measure("R2 sel3 pre16 duty2", 32, -1);
    restart(2'd1, 0, 1);
    measure("R2 pre4 duty1", 4, -1);

    // R4: single-step duty at 1:1
    curReq = "R4";
    restart(2'd0, 3, 1);
    measure("R4 duty1 P1", 1, -1);

    // R9: disable mid-pulse
    curReq = "R9";
    restart(2'd0, 9, 30);
    measure("R9 pre-disable", 30, -1);
    repeat (4) @(negedge clk);
    check("R9 high mid-pulse", int'(pwmOut), 1);
    #1 enable = 1'b0;
    @(negedge clk);
    check("R9 low after disable", int'(pwmOut), 0);
    repeat (10) @(negedge clk);
    check("R9 still low", int'(pwmOut), 0);
    @(posedge clk); #2;
    enable = 1'b1;
    highs = 0;
    for (int k = 0; k < 39; k++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
    check("R9 low until first boundary", highs, 0);
    measure("R9 resumes", 30, -1);

    // R3/R6: full-width timer
    curReq = "R3";
    restart(2'd0, 255, 1000);
    measure("R3 period255 duty1000", 1000, -1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule